// File: doc/BRIEF.md
# Periodic Limit Timer Bank

This block holds a set of periodic microsecond timers. There is one timer for each processor and one shared system timer. Each timer counts the pulses of a 1 MHz tick-enable input. When its count meets a programmed limit, the timer latches a pending flag, raises its interrupt line and starts again from one. The system timer drives the level-10 interrupt line. Each per-processor timer drives its own level-14 line.

Software reaches the timers through a plain 32-bit register port. Each timer has a limit word, a count word and a second alias of the limit word. A read of the limit word acknowledges the interrupt. A write through the alias changes the limit and leaves the counter and the pending flag alone. Per-processor timers also have a run control word. Count and limit values sit in bits 30:10, so bit 10 stands for one microsecond. A period of P microseconds is programmed as (P+1) shifted left by 10.

The register port has no back-pressure. A request is taken on every clock in which `bus_req` is high. Read data comes back on the next cycle with `bus_rvalid`. The pending flags are plain level outputs.

Top module: `limit_timer_bank`

## Requirements
- R1: After reset, every limit is zero, every count is one, every run bit is one, every interrupt output is low, and register reads return those values.
- R2: The count word reads the pending flag in bit 31, the count in bits 30:10 and zero in bits 9:0. A running timer with a nonzero limit adds one to its count on each clock where `tick_en` is high.
- R3: A tick whose incremented count equals the nonzero limit sets the pending flag and reloads the count to one. The interrupt output is high from the next cycle. With a limit of (P+1)<<10, hits come every P ticks.
- R4: Reading word 0 (limit) returns the pending flag in bit 31 and the limit in bits 30:10, and clears the pending flag. If a hit occurs in the same cycle, the flag stays set.
- R5: While a timer's limit is zero, its count holds and it raises no interrupt.
- R6: Writing word 0 loads the limit from bits 30:10, sets the count to one and clears the pending flag. Writing word 2 loads the limit only. Reading word 2 returns the same value as word 0 but does not clear the flag.
- R7: On a per-processor timer, word 3 bit 0 is the run bit (1 = run). While it is 0, the count holds. On the system timer, word 3 reads zero and writes to it are ignored.
- R8: The address is {timer index, word[2:0]}. Indexes 0..NCPU-1 are the per-processor timers, which drive `irq_l14[i]`. Index NCPU is the system timer, which drives `irq_l10`. Word 4 and above, word 3 of the system timer, and any index above NCPU all read zero.
- R9: A read request returns its data with `bus_rvalid` high exactly one cycle later. `bus_rvalid` is low in every other cycle.

Port widths below use the default NCPU of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-microsecond count enable |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | {timer index, word} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq_l10 | output | 1 | System timer pending |
| irq_l14 | output | 2 | Per-processor timer pending |

## Verification
A bad count or limit register shows up at the ports in two ways. An interrupt rises on the wrong tick, and that is visible one cycle after the faulty hit. A count read also returns the wrong value, visible on the next read. A pending flag that is lost, or that sticks, shows on the interrupt pin in the very next cycle. The bench runs a behavioural model next to the design and compares every interrupt pin and every returned read word on every clock. Any divergence is therefore reported within one cycle of reaching a port.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_BIT = 31;
  localparam int WORD_W = 3;

  typedef enum logic [WORD_W-1:0] {
    W_LIMIT = 3'd0,
    W_COUNT = 3'd1,
    W_NOCLR = 3'd2,
    W_CTRL  = 3'd3,
    W_CFG   = 3'd4
  } word_e;
endpackage

// File: rtl/lt_core.sv
module lt_core
  import lt_pkg::*;
#(
  parameter bit HAS_CTRL = 1'b1,
  parameter int CNT_W = 21,
  parameter int SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sel,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  wr_field,
  input  logic              wr_bit0,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq
);
  localparam int MSB = SHIFT + CNT_W - 1;

  logic [CNT_W-1:0] lim_q, cnt_q, nxt;
  logic pend_q, run_q;
  logic wr_lim, wr_nc, wr_ctl, rd_lim, adv, hit;

  assign wr_lim = sel && we && (word == W_LIMIT);
  assign wr_nc  = sel && we && (word == W_NOCLR);
  assign wr_ctl = sel && we && (word == W_CTRL) && HAS_CTRL;
  assign rd_lim = sel && !we && (word == W_LIMIT);
  assign adv    = tick && run_q && (lim_q != '0);
  assign nxt    = cnt_q + 1'b1;
  assign hit    = adv && (nxt == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      cnt_q  <= CNT_W'(1);
      pend_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      if (wr_lim) begin
        lim_q  <= wr_field;
        cnt_q  <= CNT_W'(1);
        pend_q <= 1'b0;
      end else begin
        if (adv) cnt_q <= hit ? CNT_W'(1) : nxt;
        if (hit) pend_q <= 1'b1;
        else if (rd_lim) pend_q <= 1'b0;
        if (wr_nc) lim_q <= wr_field;
      end
      if (wr_ctl) run_q <= wr_bit0;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (word)
      W_LIMIT, W_NOCLR: begin
        rd_val[FLAG_BIT] = pend_q;
        rd_val[MSB:SHIFT] = lim_q;
      end
      W_COUNT: begin
        rd_val[FLAG_BIT] = pend_q;
        rd_val[MSB:SHIFT] = cnt_q;
      end
      W_CTRL: rd_val[0] = HAS_CTRL ? run_q : 1'b0;
      default: rd_val = '0;
    endcase
  end

  assign irq = pend_q;

  // R3: a fresh hit always leaves the counter at one
  assert_reload_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (cnt_q == CNT_W'(1)));

  // R4: acknowledge read without a coincident hit clears the flag
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !hit) |=> !pend_q);

  // R5: a zero limit never produces an interrupt
  assert_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && !pend_q) |=> !pend_q);

  // R6: the alias write keeps a pending flag
  assert_noclear_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nc && pend_q) |=> pend_q);

  // R7: a stopped timer holds its count
  assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_lim) |=> $stable(cnt_q));
endmodule

// File: rtl/lt_rdport.sv
module lt_rdport
  import lt_pkg::*;
#(
  parameter int NT = 3,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [IDX_W-1:0]           idx,
  input  logic [NT-1:0][DATA_W-1:0]  vals,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NT; i++)
      if (idx == IDX_W'(i)) pick = vals[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= pick;
    end
  end

  // R9: every read answers exactly one cycle later
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid);
endmodule

// File: rtl/limit_timer_bank.sv
module limit_timer_bank
  import lt_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int CNT_W = 21,
  parameter int SHIFT = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_en,
  input  logic                              bus_req,
  input  logic                              bus_we,
  input  logic [$clog2(NCPU+1)+WORD_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic                              bus_rvalid,
  output logic                              irq_l10,
  output logic [NCPU-1:0]                   irq_l14
);
  localparam int NT = NCPU + 1;
  localparam int IDX_W = $clog2(NT);
  localparam int MSB = SHIFT + CNT_W - 1;
  localparam logic [DATA_W-1:0] USED =
    ((DATA_W'(1) << (CNT_W)) - 1) << SHIFT | DATA_W'(1);

  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] word;
  logic [NT-1:0][DATA_W-1:0] vals;
  logic [NT-1:0] irqs;
  logic unused_bits;

  assign idx  = bus_addr[IDX_W+WORD_W-1:WORD_W];
  assign word = bus_addr[WORD_W-1:0];
  assign unused_bits = ^(bus_wdata & ~USED);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    lt_core #(
      .HAS_CTRL(i < NCPU),
      .CNT_W(CNT_W),
      .SHIFT(SHIFT)
    ) u_core (
      .clk(clk),
      .rst_n(rst_n),
      .tick(tick_en),
      .sel(bus_req && (idx == IDX_W'(i))),
      .we(bus_we),
      .word(word),
      .wr_field(bus_wdata[MSB:SHIFT]),
      .wr_bit0(bus_wdata[0]),
      .rd_val(vals[i]),
      .irq(irqs[i])
    );
  end

  assign irq_l14 = irqs[NCPU-1:0];
  assign irq_l10 = irqs[NCPU];

  lt_rdport #(.NT(NT), .IDX_W(IDX_W)) u_rd (
    .clk(clk),
    .rst_n(rst_n),
    .rd_req(bus_req && !bus_we),
    .idx(idx),
    .vals(vals),
    .rdata(bus_rdata),
    .rvalid(bus_rvalid)
  );
endmodule

// File: tb/limit_timer_bank_test.sv
module limit_timer_bank_test;
  localparam int NCPU = 2;
  localparam int NT = NCPU + 1;
  localparam int AW = 5;
  localparam int CMASK = (1 << 21) - 1;

  logic clk = 0, rst_n = 0, tick_en = 0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq_l10;
  logic [NCPU-1:0] irq_l14;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  limit_timer_bank #(.NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_l10(irq_l10), .irq_l14(irq_l14));

  // behavioural reference
  int mlim[NT], mcnt[NT];
  bit mpend[NT], mrun[NT];
  bit exp_rv;
  logic [31:0] exp_rd;
  string exp_tag;

  function automatic logic [31:0] mread(int t, int w);
    logic [31:0] v = '0;
    if (t >= NT) return '0;
    if (w == 0 || w == 2) v = {mpend[t], 31'(mlim[t]) << 10};
    else if (w == 1) v = {mpend[t], 31'(mcnt[t]) << 10};
    else if (w == 3 && t < NCPU) v = 32'(mrun[t]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        mlim[t] = 0; mcnt[t] = 1; mpend[t] = 0; mrun[t] = 1;
      end
      exp_rv = 0;
    end else begin
      int ti, w;
      ti = int'(bus_addr[4:3]);
      w = int'(bus_addr[2:0]);
      exp_rv = bus_req && !bus_we;
      if (exp_rv) begin
        exp_rd = mread(ti, w);
        exp_tag = (w == 0 || w == 2) ? "R4" : (w == 1) ? "R2" :
                  (w == 3 && ti < NCPU) ? "R7" : "R8";
      end
      for (int t = 0; t < NT; t++) begin
        bit s, hit;
        int n;
        s = bus_req && ti == t;
        hit = 0;
        if (s && bus_we && w == 0) begin
          mlim[t] = int'(bus_wdata[30:10]); mcnt[t] = 1; mpend[t] = 0;
        end else begin
          if (tick_en && mrun[t] && mlim[t] != 0) begin
            n = (mcnt[t] + 1) & CMASK;
            if (n == mlim[t]) begin mcnt[t] = 1; mpend[t] = 1; hit = 1; end
            else mcnt[t] = n;
          end
          if (s && !bus_we && w == 0 && !hit) mpend[t] = 0;
          if (s && bus_we && w == 2) mlim[t] = int'(bus_wdata[30:10]);
          if (s && bus_we && w == 3 && t < NCPU) mrun[t] = bus_wdata[0];
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NCPU; t++) check("R3 irq_l14", 32'(irq_l14[t]), 32'(mpend[t]));
      check("R3 irq_l10", 32'(irq_l10), 32'(mpend[NCPU]));
      check("R9 rvalid", 32'(bus_rvalid), 32'(exp_rv));
      if (exp_rv && bus_rvalid) check(exp_tag, bus_rdata, exp_rd);
    end
  end

  task automatic wr(int t, int w, logic [31:0] d);
    @(posedge clk); #1;
    bus_req = 1; bus_we = 1; bus_addr = {2'(t), 3'(w)}; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(int t, int w, output logic [31:0] v);
    @(posedge clk); #1;
    bus_req = 1; bus_we = 0; bus_addr = {2'(t), 3'(w)};
    @(posedge clk); #1;
    bus_req = 0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(0, 1, v); check("R1 count reset", v, 32'h0000_0400);
    rd(2, 0, v); check("R1 limit reset", v, 32'h0);
    rd(1, 3, v); check("R1 run reset", v, 32'h1);
    check("R1 irq reset", {irq_l10, 30'b0, irq_l14[0]}, 32'h0);

    // R3 period: P=4 on global timer, tick every cycle
    tick_en = 1;
    wr(2, 0, 32'(5) << 10);
    n = 0;
    while (!irq_l10 && n < 50) begin @(negedge clk); n++; end
    check("R3 period P+1 edges", 32'(n), 32'd5);
    // R4 read acknowledges and shows flag
    tick_en = 0;
    rd(2, 0, v); check("R4 limit read", v, 32'h8000_1400);
    @(negedge clk); check("R4 cleared", 32'(irq_l10), 32'h0);

    // R5 zero limit timer 0 stayed put
    rd(0, 1, v); check("R5 held count", v, 32'h0000_0400);

    // R2 counting
    wr(0, 0, 32'(100) << 10);
    tick_en = 1; idle(7); tick_en = 0;
    rd(0, 1, v); check("R2 count after ticks", v, 32'(8) << 10);

    // R7 stop / start
    wr(0, 3, 32'h0);
    tick_en = 1; idle(10);
    rd(0, 1, v); rd(0, 1, v2);
    check("R7 stopped hold", v2, v);
    wr(0, 3, 32'h1); idle(5); tick_en = 0;

    // R6 alias write keeps pending
    wr(1, 0, 32'(3) << 10);
    tick_en = 1; idle(4); tick_en = 0;
    check("R6 pend before", 32'(irq_l14[1]), 32'h1);
    wr(1, 2, 32'(9) << 10);
    @(negedge clk); check("R6 pend kept", 32'(irq_l14[1]), 32'h1);
    rd(1, 2, v); check("R6 alias read", v, 32'h8000_2400);
    @(negedge clk); check("R6 alias no clear", 32'(irq_l14[1]), 32'h1);
    wr(1, 0, 32'(9) << 10);
    @(negedge clk); check("R6 limit write clears", 32'(irq_l14[1]), 32'h0);

    // R4 hit wins over acknowledge (limit 2 hits every tick)
    wr(1, 0, 32'(2) << 10);
    tick_en = 1; idle(3);
    rd(1, 0, v);
    @(negedge clk); check("R4 hit wins", 32'(irq_l14[1]), 32'h1);
    tick_en = 0;
    rd(1, 0, v);
    @(negedge clk); check("R4 clear idle", 32'(irq_l14[1]), 32'h0);

    // R8 address map
    rd(3, 0, v); check("R8 unused index", v, 32'h0);
    wr(2, 3, 32'h1);
    rd(2, 3, v); check("R8 global ctrl zero", v, 32'h0);
    rd(0, 4, v); check("R8 word4 zero", v, 32'h0);

    // mixed traffic, model compares every clock
    for (int k = 0; k < 400; k++) begin
      tick_en = (k % 3) != 1;
      case (k % 7)
        0: wr(k % 3, 0, 32'((k % 6) + 2) << 10);
        1: rd(k % 3, 0, v);
        2: wr(k % 3, 2, 32'((k % 5) + 3) << 10);
        3: rd(k % 3, 1, v);
        4: wr(k % 2, 3, 32'(k % 2));
        default: idle(2);
      endcase
    end
    tick_en = 0; idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule